// File: doc/BRIEF.md
# Flash Control and Event Flag Register Unit

This unit sits on the special-function register bus of an 8-bit microcontroller. It serves three byte-wide registers. The first is a flash control register. Its program-write enable steers data-pointer external-move writes into program flash instead of data RAM. It also carries a mass-erase arm bit, a sticky security latch and a live preboot status bit.

The second register is a flag register. Its flags are set by hardware event pulses and cleared by software with a write-zero-to-clear byte write. The third register is read-only and shows the live levels of seven external interrupt lines.

Each stored bit keeps its own update rule:
- it clears itself after one flash byte;
- it clears when an erase starts;
- it can only ever be set;
- it is set by hardware and cleared by software.

Reads are combinational from the bus address. Writes take effect on the next rising clock edge.

Top module: `sfr_flash_ctrl`

## Requirements
- R1: After reset all stored bits are 0, `prog_wr_en_o`, `mass_erase_en_o` and `secure_o` are low, and `ext_read_ok_o` is high.
- R2: A write to address 0xB2 with interrupts disabled loads bit 0 into the program-write enable (`prog_wr_en_o`, read back at bit 0). A `byte_written_i` pulse clears it. When the pulse and a write happen in the same cycle, the clear wins.
- R3: While `irq_en_i` is high, writes to 0xB2 leave the program-write enable unchanged. Bits 1 and 6 are still written.
- R4: Bit 1 of 0xB2 is the mass-erase enable (`mass_erase_en_o`). An `erase_start_i` pulse clears it, and the clear wins over a same-cycle write.
- R5: Bit 6 of 0xB2 is the security latch (`secure_o`). Writing 1 sets it and writing 0 has no effect, so only reset clears it. While it is set, `ext_read_ok_o` is low.
- R6: Bit 7 of 0xB2 reads the live level of `preboot_i` and cannot be written.
- R7: The flag register at 0xF8 holds the transfer flag in bit 0 and the tick flag in bit 1. A `xfer_evt_i` or `tick_evt_i` pulse sets the matching flag, and the flag stays set. A write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1.
- R8: When a hardware event and a software clear hit the same flag in one cycle, the flag ends set.
- R9: A read of 0xE8 returns `ext_int_i[6:0]` on bits 0 to 6 with bit 7 at 0. It follows input changes without a clock.
- R10: Bits 2 to 5 of 0xB2 and bits 2 to 7 of 0xF8 read 0. Other addresses read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Write data |
| sfr_we_i | input | 1 | Write strobe |
| sfr_rdata_o | output | 8 | Read data for `sfr_addr_i` |
| irq_en_i | input | 1 | Interrupts globally enabled |
| byte_written_i | input | 1 | One flash byte was programmed |
| erase_start_i | input | 1 | A mass erase cycle starts |
| preboot_i | input | 1 | Preboot sequence active |
| xfer_evt_i | input | 1 | Transfer-busy event pulse |
| tick_evt_i | input | 1 | 0.8 s tick event pulse |
| ext_int_i | input | 7 | External interrupt line levels |
| prog_wr_en_o | output | 1 | Steer external-move writes to flash |
| mass_erase_en_o | output | 1 | Mass erase armed |
| secure_o | output | 1 | Security latch |
| ext_read_ok_o | output | 1 | External flash read permitted |
| flags_o | output | 2 | Flag register contents |

## Verification
The control register is driven with a lone write, with a write under enabled interrupts, and with a write that collides with a byte-written or erase-start pulse. These patterns separate a missing interrupt guard from a wrong collision priority. The flag register is tried with single events, with all-ones writes, with a zero in one bit position, and with an event that coincides with a clear. A write that clears the wrong bit or lets the clear beat the event is therefore distinguished from a correct one. The security latch receives a set and then a zero write, which exposes a latch that is writable both ways. Live reads use two complementary interrupt patterns, and unmapped addresses confirm that nothing leaks into unused bits.

// File: rtl/sfr_flash_pkg.sv
package sfr_flash_pkg;
  parameter int unsigned DATA_W    = 8;
  parameter int unsigned ADDR_W    = 8;
  parameter int unsigned N_FLAGS   = 2;
  parameter int unsigned N_EXT_INT = 7;

  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hB2;
  parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'hF8;
  parameter logic [ADDR_W-1:0] INTS_ADDR  = 8'hE8;

  // control register bit positions, decoded by software
  parameter int unsigned PWE_BIT     = 0;
  parameter int unsigned MEEN_BIT    = 1;
  parameter int unsigned SECURE_BIT  = 6;
  parameter int unsigned PREBOOT_BIT = 7;

  typedef struct packed {
    logic pwe;
    logic meen;
    logic secure;
  } ctrl_state_t;
endpackage

// File: rtl/flash_ctrl_reg.sv
module flash_ctrl_reg
  import sfr_flash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_en_i,
  input  logic              byte_done_i,
  input  logic              erase_start_i,
  output ctrl_state_t       state_o
);
  ctrl_state_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      // program write enable: one-shot, guarded by interrupt enable
      if (byte_done_i)             q.pwe <= 1'b0;
      else if (wr_i && !irq_en_i)  q.pwe <= wdata_i[PWE_BIT];
      // mass erase arm: consumed by erase start
      if (erase_start_i)           q.meen <= 1'b0;
      else if (wr_i)               q.meen <= wdata_i[MEEN_BIT];
      // security: set-only
      if (wr_i && wdata_i[SECURE_BIT]) q.secure <= 1'b1;
    end
  end

  assign state_o = q;
endmodule

// File: rtl/event_flag_reg.sv
module event_flag_reg #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (evt_i[i]) f_q <= 1'b1;        // set beats clear
      else if (wr_i)     f_q <= f_q & wdata_i[i];
    end
    assign flags_o[i] = f_q;
  end
endmodule

// File: rtl/sfr_read_mux.sv
module sfr_read_mux
  import sfr_flash_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ctrl_view_i,
  input  logic [DATA_W-1:0] flags_view_i,
  input  logic [DATA_W-1:0] ints_view_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    unique case (addr_i)
      CTRL_ADDR:  rdata_o = ctrl_view_i;
      FLAGS_ADDR: rdata_o = flags_view_i;
      INTS_ADDR:  rdata_o = ints_view_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sfr_flash_ctrl.sv
module sfr_flash_ctrl
  import sfr_flash_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    sfr_addr_i,
  input  logic [DATA_W-1:0]    sfr_wdata_i,
  input  logic                 sfr_we_i,
  output logic [DATA_W-1:0]    sfr_rdata_o,
  input  logic                 irq_en_i,
  input  logic                 byte_written_i,
  input  logic                 erase_start_i,
  input  logic                 preboot_i,
  input  logic                 xfer_evt_i,
  input  logic                 tick_evt_i,
  input  logic [N_EXT_INT-1:0] ext_int_i,
  output logic                 prog_wr_en_o,
  output logic                 mass_erase_en_o,
  output logic                 secure_o,
  output logic                 ext_read_ok_o,
  output logic [N_FLAGS-1:0]   flags_o
);
  localparam int unsigned FLAG_PAD = DATA_W - N_FLAGS;
  localparam int unsigned INT_PAD  = DATA_W - N_EXT_INT;

  logic        ctrl_wr, flags_wr;
  ctrl_state_t ctrl_q;
  logic [DATA_W-1:0] ctrl_view, flags_view, ints_view;

  assign ctrl_wr  = sfr_we_i && (sfr_addr_i == CTRL_ADDR);
  assign flags_wr = sfr_we_i && (sfr_addr_i == FLAGS_ADDR);

  flash_ctrl_reg u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (ctrl_wr),
    .wdata_i       (sfr_wdata_i),
    .irq_en_i      (irq_en_i),
    .byte_done_i   (byte_written_i),
    .erase_start_i (erase_start_i),
    .state_o       (ctrl_q)
  );

  event_flag_reg #(.N(N_FLAGS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (flags_wr),
    .wdata_i (sfr_wdata_i[N_FLAGS-1:0]),
    .evt_i   ({tick_evt_i, xfer_evt_i}),
    .flags_o (flags_o)
  );

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[PWE_BIT]     = ctrl_q.pwe;
    ctrl_view[MEEN_BIT]    = ctrl_q.meen;
    ctrl_view[SECURE_BIT]  = ctrl_q.secure;
    ctrl_view[PREBOOT_BIT] = preboot_i;
  end

  assign flags_view = {{FLAG_PAD{1'b0}}, flags_o};
  assign ints_view  = {{INT_PAD{1'b0}}, ext_int_i};

  sfr_read_mux u_rmux (
    .addr_i       (sfr_addr_i),
    .ctrl_view_i  (ctrl_view),
    .flags_view_i (flags_view),
    .ints_view_i  (ints_view),
    .rdata_o      (sfr_rdata_o)
  );

  assign prog_wr_en_o    = ctrl_q.pwe;
  assign mass_erase_en_o = ctrl_q.meen;
  assign secure_o        = ctrl_q.secure;
  assign ext_read_ok_o   = ~ctrl_q.secure;
endmodule

// File: rtl/sfr_flash_ctrl_chk.sv
module sfr_flash_ctrl_chk
  import sfr_flash_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    sfr_addr_i,
  input logic [DATA_W-1:0]    sfr_wdata_i,
  input logic                 sfr_we_i,
  input logic                 irq_en_i,
  input logic                 byte_written_i,
  input logic                 erase_start_i,
  input logic                 xfer_evt_i,
  input logic                 tick_evt_i,
  input logic                 prog_wr_en_o,
  input logic                 mass_erase_en_o,
  input logic                 secure_o,
  input logic [N_FLAGS-1:0]   flags_o
);
  logic ctrl_wr, flags_wr;
  assign ctrl_wr  = sfr_we_i && (sfr_addr_i == CTRL_ADDR);
  assign flags_wr = sfr_we_i && (sfr_addr_i == FLAGS_ADDR);

  assert_pwe_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_written_i |=> !prog_wr_en_o);

  assert_pwe_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && !byte_written_i) |=> $stable(prog_wr_en_o));

  assert_meen_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_i |=> !mass_erase_en_o);

  assert_secure_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secure_o |=> secure_o);

  assert_secure_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(secure_o) |-> $past(ctrl_wr && sfr_wdata_i[SECURE_BIT]));

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[0] && !flags_wr) |=> flags_o[0]);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_evt_i || tick_evt_i) |=> (flags_o[0] || !$past(xfer_evt_i)) && (flags_o[1] || !$past(tick_evt_i)));
endmodule

bind sfr_flash_ctrl sfr_flash_ctrl_chk u_chk (.*);

// File: tb/sfr_flash_ctrl_tb.sv
module sfr_flash_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sfr_addr_i = '0, sfr_wdata_i = '0, sfr_rdata_o;
  logic       sfr_we_i = 0, irq_en_i = 0, byte_written_i = 0, erase_start_i = 0;
  logic       preboot_i = 0, xfer_evt_i = 0, tick_evt_i = 0;
  logic [6:0] ext_int_i = '0;
  logic       prog_wr_en_o, mass_erase_en_o, secure_o, ext_read_ok_o;
  logic [1:0] flags_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  sfr_flash_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0; irq_en_i = 0; preboot_i = 0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); sfr_addr_i = a; sfr_wdata_i = d; sfr_we_i = 1;
    @(negedge clk_i); sfr_we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr_i = a; #1; d = sfr_rdata_o;
  endtask

  task automatic test_reset();
    logic [7:0] d;
    rd(8'hB2, d); chk("R1 ctrl", d, 8'h00);
    rd(8'hF8, d); chk("R1 flags", d, 8'h00);
    chk("R1 outs", {4'b0, prog_wr_en_o, mass_erase_en_o, secure_o, ext_read_ok_o}, 8'h01);
  endtask

  task automatic test_pwe();
    logic [7:0] d;
    wr(8'hB2, 8'h01);
    rd(8'hB2, d); chk("R2 set", d, 8'h01);
    chk("R2 pin", {7'b0, prog_wr_en_o}, 8'h01);
    @(negedge clk_i); byte_written_i = 1; @(negedge clk_i); byte_written_i = 0;
    chk("R2 cleared", {7'b0, prog_wr_en_o}, 8'h00);
    @(negedge clk_i); sfr_addr_i = 8'hB2; sfr_wdata_i = 8'h01; sfr_we_i = 1; byte_written_i = 1;
    @(negedge clk_i); sfr_we_i = 0; byte_written_i = 0;
    chk("R2 collide", {7'b0, prog_wr_en_o}, 8'h00);
  endtask

  task automatic test_guard();
    logic [7:0] d;
    irq_en_i = 1;
    wr(8'hB2, 8'h03);
    rd(8'hB2, d); chk("R3 blocked set", d, 8'h02);
    irq_en_i = 0; wr(8'hB2, 8'h01); irq_en_i = 1;
    wr(8'hB2, 8'h00);
    rd(8'hB2, d); chk("R3 blocked clear", d, 8'h01);
    irq_en_i = 0; wr(8'hB2, 8'h00);
  endtask

  task automatic test_meen();
    wr(8'hB2, 8'h02);
    chk("R4 set", {7'b0, mass_erase_en_o}, 8'h01);
    @(negedge clk_i); erase_start_i = 1; @(negedge clk_i); erase_start_i = 0;
    chk("R4 erase clr", {7'b0, mass_erase_en_o}, 8'h00);
    @(negedge clk_i); sfr_addr_i = 8'hB2; sfr_wdata_i = 8'h02; sfr_we_i = 1; erase_start_i = 1;
    @(negedge clk_i); sfr_we_i = 0; erase_start_i = 0;
    chk("R4 collide", {7'b0, mass_erase_en_o}, 8'h00);
  endtask

  task automatic test_secure();
    logic [7:0] d;
    wr(8'hB2, 8'h40);
    chk("R5 set", {6'b0, secure_o, ext_read_ok_o}, 8'h02);
    wr(8'hB2, 8'h00);
    rd(8'hB2, d); chk("R5 zero ignored", d, 8'h40);
    chk("R5 read gate", {7'b0, ext_read_ok_o}, 8'h00);
    do_reset();
    chk("R5 reset clears", {7'b0, secure_o}, 8'h00);
  endtask

  task automatic test_preboot();
    logic [7:0] d;
    preboot_i = 1; rd(8'hB2, d); chk("R6 high", d, 8'h80);
    wr(8'hB2, 8'h00); rd(8'hB2, d); chk("R6 not writable", d, 8'h80);
    preboot_i = 0; rd(8'hB2, d); chk("R6 low", d, 8'h00);
  endtask

  task automatic pulse_evt(input logic x, input logic t);
    @(negedge clk_i); xfer_evt_i = x; tick_evt_i = t;
    @(negedge clk_i); xfer_evt_i = 0; tick_evt_i = 0;
  endtask

  task automatic test_flags();
    logic [7:0] d;
    pulse_evt(1, 0); rd(8'hF8, d); chk("R7 xfer", d, 8'h01);
    repeat (3) @(negedge clk_i);
    rd(8'hF8, d); chk("R7 held", d, 8'h01);
    pulse_evt(0, 1); rd(8'hF8, d); chk("R7 tick", d, 8'h03);
    wr(8'hF8, 8'hFE); rd(8'hF8, d); chk("R7 clr bit0", d, 8'h02);
    wr(8'hF8, 8'hFF); rd(8'hF8, d); chk("R7 ones keep", d, 8'h02);
    wr(8'hF8, 8'hFD); rd(8'hF8, d); chk("R7 clr bit1", d, 8'h00);
  endtask

  task automatic test_set_wins();
    @(negedge clk_i); sfr_addr_i = 8'hF8; sfr_wdata_i = 8'h00; sfr_we_i = 1; xfer_evt_i = 1;
    @(negedge clk_i); sfr_we_i = 0; xfer_evt_i = 0;
    chk("R8 set wins", {6'b0, flags_o}, 8'h01);
    wr(8'hF8, 8'h00);
  endtask

  task automatic test_ints();
    logic [7:0] d;
    ext_int_i = 7'h55; rd(8'hE8, d); chk("R9 pat a", d, 8'h55);
    ext_int_i = 7'h2A; rd(8'hE8, d); chk("R9 pat b", d, 8'h2A);
    ext_int_i = 7'h7F; rd(8'hE8, d); chk("R9 all", d, 8'h7F);
  endtask

  task automatic test_unused();
    logic [7:0] d;
    wr(8'hB2, 8'h3C); rd(8'hB2, d); chk("R10 ctrl unused", d, 8'h00);
    pulse_evt(1, 1); wr(8'hF8, 8'hFF); rd(8'hF8, d); chk("R10 flag unused", d, 8'h03);
    wr(8'h10, 8'hFF); rd(8'hB2, d); chk("R10 stray write", d, 8'h00);
    rd(8'h10, d); chk("R10 unmapped", d, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    test_reset();
    test_pwe();
    test_guard();
    test_meen();
    test_secure();
    test_preboot();
    test_flags();
    test_set_wins();
    test_ints();
    test_unused();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule